// File: doc/BRIEF.md
# Manchester II Word Decoder

This block turns an oversampled Manchester II serial line into sixteen-bit words. It runs from a single clock at twelve times the bit rate. The line arrives either as a complementary pair from a differential receiver or as one non-inverted level, and a select input picks the source. The decoder hunts continuously for a sync character. A sync is a 1.5-bit-time level followed by 1.5 bit times at the opposite level. If the leading half is high the sync is a command sync; if it is low it is a data sync.

Seventeen bit cells follow the sync: sixteen data bits and a parity bit. A logic one is sent as high then low within its cell, and a logic zero as low then high. The block only commits to a word once the sync and the first two data bits have decoded cleanly. It then presents the data as NRZ on a serial output, first-received bit first, together with a shift clock and a take-data strobe. The first-received bit is bit 15. When the word completes with odd parity and no coding errors, a valid flag is raised for a fixed window.

Top module: `mdec_top`

## Requirements
- R1: With `src_sel`=1 only `uni_in` is decoded and the pair inputs are ignored. With `src_sel`=0 a line level of one is `bip_one` high with `bip_zero` low, and zero is the reverse.
- R2: During an output window `cmd_sync` is high for all sixteen shift-clock rises if the sync's first half was high, and low for all of them if it was low.
- R3: A sync is accepted only when its first half lasts 16 to 20 clocks and its second half lasts at least 16 clocks. A 14- or 22-clock first half, or a 12-clock second half, produces no output window.
- R4: `take_data` rises only after the sync and data bits 15 and 14 have decoded without error. It then stays high for exactly 16 shift-clock periods (192 clocks).
- R5: `sdata` carries the received bits in arrival order, bit 15 first, one per shift-clock period, and is stable at each rising edge of `sclk`. A window begins with `sclk` low.
- R6: `valid_word` rises after the window only when the 17 received bits contain an odd number of ones.
- R7: A cell whose two halves are at the same level aborts the word: `take_data` drops early and `valid_word` does not rise.
- R8: In pair mode, both inputs high at once inside the word aborts it in the same way as R7.
- R9: `valid_word` stays high for 240 clocks (20 shift-clock periods). It is cleared in the same cycle that `take_data` rises for a following word.
- R10: `dec_rst` high in the first clock of an `sclk` high phase aborts any reception. The decoder then accepts the next word normally.
- R11: While `rst_n` is low, `take_data`, `cmd_sync`, `sdata` and `valid_word` are low.
- R12: With the line idle, `sclk` has a 12-clock period and is high for 6 clocks of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 12x bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_rst | input | 1 | Abort request, honoured at shift-clock rise |
| src_sel | input | 1 | 1 = single-line input, 0 = complementary pair |
| bip_one | input | 1 | Pair input, high for a positive line level |
| bip_zero | input | 1 | Pair input, high for a negative line level |
| uni_in | input | 1 | Single-line non-inverted Manchester input |
| sdata | output | 1 | Decoded NRZ data |
| sclk | output | 1 | Shift clock, sample `sdata` on its rise |
| take_data | output | 1 | High while the sixteen bits are presented |
| cmd_sync | output | 1 | High during the window of a command-sync word |
| valid_word | output | 1 | Word received with odd parity and clean coding |

## Verification
The hardest situation to reach is a coding fault that produces no false sync afterwards. A cell held flat for 12 clocks can join a neighbouring half cell into an 18-clock run, and the hunting decoder would take that run as a new sync. The stimulus therefore holds each flat cell at the level of the preceding data bit and picks data words in which the next bit differs, so every run around the fault is 6 or 12 clocks. Early clearing of the valid flag needs two words close together. The bench sends them in pair mode with an idle gap in between, so the second word's window opens while the first word's flag is still up.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SYNC2 = 2'd1,
    ST_DATA  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/mdec_front.sv
module mdec_front #(
  parameter int RUN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_sel,
  input  logic             bip_one,
  input  logic             bip_zero,
  input  logic             uni_in,
  output logic             lvl,
  output logic             act,
  output logic             bad,
  output logic             flip,
  output logic [RUN_W-1:0] run
);
  logic             lvl_n, act_n, bad_n;
  logic             lvl_q, act_q;
  logic [RUN_W-1:0] run_n;

  // source select and line qualification
  always_comb begin
    if (src_sel) begin
      lvl_n = uni_in;
      act_n = 1'b1;
      bad_n = 1'b0;
    end else begin
      lvl_n = bip_one;
      act_n = bip_one ^ bip_zero;
      bad_n = bip_one & bip_zero;
    end
  end

  assign flip = act & act_q & (lvl != lvl_q);

  // run length of the level before the current cycle
  always_comb begin
    if (!act)      run_n = '0;
    else if (flip) run_n = RUN_W'(1);
    else if (&run) run_n = run;
    else           run_n = run + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl   <= 1'b0;
      act   <= 1'b0;
      bad   <= 1'b0;
      lvl_q <= 1'b0;
      act_q <= 1'b0;
      run   <= '0;
    end else begin
      lvl   <= lvl_n;
      act   <= act_n;
      bad   <= bad_n;
      lvl_q <= lvl;
      act_q <= act;
      run   <= run_n;
    end
  end
endmodule

// File: rtl/mdec_rx.sv
module mdec_rx
  import mdec_pkg::*;
#(
  parameter int OSR      = 12,
  parameter int SYNC_TOL = 2,
  parameter int WB       = 16,
  parameter int RUN_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_rst,
  input  logic             lvl,
  input  logic             act,
  input  logic             bad,
  input  logic             flip,
  input  logic [RUN_W-1:0] run,
  output logic             take_data,
  output logic             sdata,
  output logic             sclk,
  output logic             cmd_sync,
  output logic             start_p,
  output logic             done_ok
);
  localparam int HALF  = OSR / 2;
  localparam int SNOM  = OSR + HALF;
  localparam int SMIN  = SNOM - SYNC_TOL;
  localparam int SMAX  = SNOM + SYNC_TOL;
  localparam int PH_W  = $clog2(OSR);
  localparam int BI_W  = $clog2(WB + 2);
  localparam int S1    = HALF / 2;
  localparam int S2    = HALF + HALF / 2;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);
  localparam logic [BI_W-1:0] BI_PAR  = BI_W'(WB);
  localparam logic [BI_W-1:0] BI_TAIL = BI_W'(WB + 1);

  rx_state_e       st, st_n;
  logic [PH_W-1:0] ph, ph_n;
  logic [BI_W-1:0] bi, bi_n;
  logic            half, half_n;
  logic            h1, h1_n, h2, h2_n;
  logic            err, err_n;
  logic            is_cmd, cmd_n;
  logic [WB:0]     sh, sh_n;

  always_comb begin
    st_n    = st;
    ph_n    = (ph == PH_LAST) ? '0 : ph + 1'b1;
    bi_n    = bi;
    half_n  = half;
    h1_n    = h1;
    h2_n    = h2;
    err_n   = err;
    cmd_n   = is_cmd;
    sh_n    = sh;
    start_p = 1'b0;
    done_ok = 1'b0;
    case (st)
      ST_HUNT: begin
        if (flip && run >= RUN_W'(SMIN) && run <= RUN_W'(SMAX)) begin
          st_n   = ST_SYNC2;
          ph_n   = PH_W'(HALF + 1);
          half_n = 1'b0;
          cmd_n  = ~lvl;
          err_n  = 1'b0;
        end
      end
      ST_SYNC2: begin
        if (bad || !act) err_n = 1'b1;
        if (flip && !(half && ph >= PH_W'(SMIN - HALF))) begin
          st_n = ST_HUNT;
        end else if (ph == PH_LAST) begin
          if (half) begin
            st_n = ST_DATA;
            bi_n = '0;
          end else begin
            half_n = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (bi <= BI_PAR &&
            (bad || (!act && (ph == PH_W'(S1) || ph == PH_W'(S2)))))
          err_n = 1'b1;
        if (ph == PH_W'(S1)) h1_n = lvl;
        if (ph == PH_W'(S2)) h2_n = lvl;
        if (ph == PH_LAST) begin
          if (bi == BI_TAIL) begin
            st_n    = ST_HUNT;
            done_ok = ^sh;
          end else if (err || h1 == h2) begin
            st_n = ST_HUNT;
          end else begin
            sh_n    = {sh[WB-1:0], h1};
            bi_n    = bi + 1'b1;
            start_p = (bi == BI_W'(1));
          end
        end
      end
      default: st_n = ST_HUNT;
    endcase
    if (dec_rst && ph == PH_HALF) begin
      st_n    = ST_HUNT;
      start_p = 1'b0;
      done_ok = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_HUNT;
      ph     <= '0;
      bi     <= '0;
      half   <= 1'b0;
      h1     <= 1'b0;
      h2     <= 1'b0;
      err    <= 1'b0;
      is_cmd <= 1'b0;
      sh     <= '0;
    end else begin
      st     <= st_n;
      ph     <= ph_n;
      bi     <= bi_n;
      half   <= half_n;
      h1     <= h1_n;
      h2     <= h2_n;
      err    <= err_n;
      is_cmd <= cmd_n;
      sh     <= sh_n;
    end
  end

  assign take_data = (st == ST_DATA) && (bi >= BI_W'(2));
  assign sdata     = take_data & sh[1];
  assign sclk      = (ph >= PH_HALF);
  assign cmd_sync  = take_data & is_cmd;

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rst && sclk && ph == PH_HALF) |=> (st == ST_HUNT));

  assert_win_opens_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_data) |-> !sclk);

  assert_sync_type_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_data && $past(take_data)) |-> (cmd_sync == $past(cmd_sync)));

  assert_two_bits_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_data) |-> $past(start_p));
endmodule

// File: rtl/mdec_vhold.sv
module mdec_vhold #(
  parameter int HOLD = 240
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic valid_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    if (clr_i)           cnt_n = '0;
    else if (set_i)      cnt_n = CW'(HOLD);
    else if (cnt != '0)  cnt_n = cnt - 1'b1;
    else                 cnt_n = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  assign valid_o = (cnt != '0);

  assert_hold_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_o) |-> ($past(clr_i) || $past(cnt) == CW'(1)));
endmodule

// File: rtl/mdec_top.sv
module mdec_top #(
  parameter int OSR        = 12,
  parameter int SYNC_TOL   = 2,
  parameter int WB         = 16,
  parameter int VW_PERIODS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dec_rst,
  input  logic src_sel,
  input  logic bip_one,
  input  logic bip_zero,
  input  logic uni_in,
  output logic sdata,
  output logic sclk,
  output logic take_data,
  output logic cmd_sync,
  output logic valid_word
);
  localparam int RUN_W = $clog2(OSR + OSR / 2 + SYNC_TOL + 2);
  localparam int HOLD  = VW_PERIODS * OSR;

  logic [1:0]       rs;
  logic             rst_s;
  logic             lvl, act, bad, flip;
  logic [RUN_W-1:0] run;
  logic             start_p, done_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs <= 2'b00;
    else        rs <= {rs[0], 1'b1};
  end
  assign rst_s = rs[1];

  mdec_front #(.RUN_W(RUN_W)) u_front (
    .clk(clk), .rst_n(rst_s), .src_sel(src_sel), .bip_one(bip_one),
    .bip_zero(bip_zero), .uni_in(uni_in), .lvl(lvl), .act(act),
    .bad(bad), .flip(flip), .run(run)
  );

  mdec_rx #(.OSR(OSR), .SYNC_TOL(SYNC_TOL), .WB(WB), .RUN_W(RUN_W)) u_rx (
    .clk(clk), .rst_n(rst_s), .dec_rst(dec_rst), .lvl(lvl), .act(act),
    .bad(bad), .flip(flip), .run(run), .take_data(take_data),
    .sdata(sdata), .sclk(sclk), .cmd_sync(cmd_sync),
    .start_p(start_p), .done_ok(done_ok)
  );

  mdec_vhold #(.HOLD(HOLD)) u_vhold (
    .clk(clk), .rst_n(rst_s), .set_i(done_ok), .clr_i(start_p),
    .valid_o(valid_word)
  );

  assert_clear_at_start_R9: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(take_data) |-> !valid_word);

  assert_valid_follows_word_R6: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(valid_word) |-> $past(take_data));
endmodule

// File: tb/sim_mdec_top.sv
module sim_mdec_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic clk, rst_n, dec_rst, src_sel, bip_one, bip_zero, uni_in;
  logic sdata, sclk, take_data, cmd_sync, valid_word;

  mdec_top u0 (
    .clk(clk), .rst_n(rst_n), .dec_rst(dec_rst), .src_sel(src_sel),
    .bip_one(bip_one), .bip_zero(bip_zero), .uni_in(uni_in),
    .sdata(sdata), .sclk(sclk), .take_data(take_data),
    .cmd_sync(cmd_sync), .valid_word(valid_word)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // monitor state
  logic [15:0] cap;
  int capcnt, tdcnt, cmdhi, vwrise, vwlen;
  int per_cnt, per_last, hi_cnt, hi_last;
  logic vw_at_rise, vw_prev_rise;
  logic sclk_d = 1'b0, vw_d = 1'b0, td_d = 1'b0;

  task automatic clr_mon();
    cap = '0; capcnt = 0; tdcnt = 0; cmdhi = 0; vwrise = 0;
    vw_at_rise = 1'b0; vw_prev_rise = 1'b0;
  endtask

  initial begin
    clr_mon();
    vwlen = 0; per_cnt = 0; per_last = 0; hi_cnt = 0; hi_last = 0;
  end

  always @(negedge clk) begin
    if (take_data) tdcnt++;
    if (sclk && !sclk_d && take_data) begin
      cap = {cap[14:0], sdata};
      capcnt++;
      if (cmd_sync) cmdhi++;
    end
    if (sclk && !sclk_d) begin per_last = per_cnt; per_cnt = 1; hi_cnt = 1; end
    else begin
      per_cnt++;
      if (sclk) hi_cnt++;
      if (!sclk && sclk_d) hi_last = hi_cnt;
    end
    if (valid_word && !vw_d) begin vwrise++; vwlen = 1; end
    else if (valid_word) vwlen++;
    if (take_data && !td_d) begin vw_at_rise = valid_word; vw_prev_rise = vw_d; end
    sclk_d = sclk; vw_d = valid_word; td_d = take_data;
  end

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic put(input logic lv, input int n);
    if (src_sel) begin uni_in = lv; bip_one = 1'b1; bip_zero = 1'b1; end
    else begin bip_one = lv; bip_zero = ~lv; end
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_line(input logic lv, input int n);
    if (src_sel) uni_in = lv;
    else begin bip_one = 1'b0; bip_zero = 1'b0; end
    repeat (n) @(negedge clk);
  endtask

  // merr: cell held flat at previous bit value; both_b: pair both high mid-cell
  task automatic send(input logic cmd, input logic [15:0] data, input logic badpar,
                      input int s1, input int s2, input int merr, input int both_b);
    logic [16:0] bits;
    bits = {data, (~^data) ^ badpar};
    idle_line(~cmd, 30);
    put(cmd, s1);
    put(~cmd, s2);
    for (int i = 0; i < 17; i++) begin
      if (i == merr) put(bits[17 - i], 12);
      else if (i == both_b) begin
        put(bits[16 - i], 6);
        bip_one = 1'b1; bip_zero = 1'b1;
        repeat (3) @(negedge clk);
        put(~bits[16 - i], 3);
      end else begin
        put(bits[16 - i], 6);
        put(~bits[16 - i], 6);
      end
    end
  endtask

  // {src_sel, cmd, bad parity, data}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 1'b1, 1'b0, 16'hA5C3},
    {1'b1, 1'b0, 1'b0, 16'h0001},
    {1'b0, 1'b0, 1'b0, 16'hFFFF},
    {1'b1, 1'b1, 1'b1, 16'h8000},
    {1'b0, 1'b1, 1'b0, 16'h0000},
    {1'b1, 1'b0, 1'b0, 16'h7E81}
  };

  initial begin
    rst_n = 1'b0; dec_rst = 1'b0; src_sel = 1'b0;
    bip_one = 1'b0; bip_zero = 1'b0; uni_in = 1'b0;
    repeat (5) @(negedge clk);
    chk(take_data == 1'b0 && cmd_sync == 1'b0, "R11 reset take/cmd", int'(take_data), 0);
    chk(valid_word == 1'b0, "R11 reset valid", int'(valid_word), 0);
    chk(sdata == 1'b0, "R11 reset sdata", int'(sdata), 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(per_last == 12, "R12 sclk period", per_last, 12);
    chk(hi_last == 6, "R12 sclk high phase", hi_last, 6);

    // table of words (R1 R2 R4 R5 R6)
    for (int v = 0; v < 6; v++) begin
      src_sel = VEC[v][18];
      clr_mon();
      send(VEC[v][17], VEC[v][15:0], VEC[v][16], 18, 18, -1, -1);
      idle_line(1'b0, 40);
      chk(capcnt == 16, "R4 bit count", capcnt, 16);
      chk(tdcnt == 192, "R4 take_data length", tdcnt, 192);
      chk(cap == VEC[v][15:0], "R5/R1 data", int'(cap), int'(VEC[v][15:0]));
      chk(cmdhi == (VEC[v][17] ? 16 : 0), "R2 sync type", cmdhi, VEC[v][17] ? 16 : 0);
      chk(vwrise == (VEC[v][16] ? 0 : 1), "R6 parity valid", vwrise, VEC[v][16] ? 0 : 1);
    end
    idle_line(1'b0, 260);
    chk(vwlen == 240, "R9 valid hold length", vwlen, 240);

    // early clear of valid (R9), pair mode
    src_sel = 1'b0;
    clr_mon();
    send(1'b1, 16'h1357, 1'b0, 18, 18, -1, -1);
    idle_line(1'b0, 10);
    send(1'b0, 16'h2468, 1'b0, 18, 18, -1, -1);
    idle_line(1'b0, 40);
    chk(vw_prev_rise == 1'b1, "R9 valid high before next window", int'(vw_prev_rise), 1);
    chk(vw_at_rise == 1'b0, "R9 valid cleared at take_data rise", int'(vw_at_rise), 0);
    chk(vwrise == 2, "R9 both words valid", vwrise, 2);

    // sync timing (R3)
    clr_mon();
    send(1'b1, 16'hA5C3, 1'b0, 14, 18, -1, -1);
    idle_line(1'b0, 40);
    chk(tdcnt == 0, "R3 short first half rejected", tdcnt, 0);
    src_sel = 1'b1;
    clr_mon();
    send(1'b0, 16'h3C3C, 1'b0, 22, 18, -1, -1);
    idle_line(1'b0, 40);
    chk(tdcnt == 0, "R3 long first half rejected", tdcnt, 0);
    src_sel = 1'b0;
    clr_mon();
    send(1'b1, 16'h9ABC, 1'b0, 20, 18, -1, -1);
    idle_line(1'b0, 40);
    chk(capcnt == 16 && cap == 16'h9ABC, "R3 first half 20 accepted", int'(cap), 16'h9ABC);
    clr_mon();
    send(1'b1, 16'h8421, 1'b0, 18, 12, -1, -1);
    idle_line(1'b0, 40);
    chk(tdcnt == 0, "R3 short second half rejected", tdcnt, 0);

    // Manchester faults (R7 R4)
    clr_mon();
    send(1'b1, 16'h0C00, 1'b0, 18, 18, 5, -1);
    idle_line(1'b0, 40);
    chk(capcnt > 0 && capcnt < 16, "R7 flat cell aborts", capcnt, 4);
    chk(vwrise == 0, "R7 no valid after fault", vwrise, 0);
    clr_mon();
    send(1'b1, 16'h6000, 1'b0, 18, 18, 1, -1);
    idle_line(1'b0, 40);
    chk(tdcnt == 0, "R4 fault in second bit gives no window", tdcnt, 0);

    // both pair inputs high (R8)
    clr_mon();
    send(1'b0, 16'hA5C3, 1'b0, 18, 18, -1, 6);
    idle_line(1'b0, 40);
    chk(capcnt < 16, "R8 both-high aborts", capcnt, 5);
    chk(vwrise == 0, "R8 no valid", vwrise, 0);

    // abort request (R10)
    clr_mon();
    fork
      send(1'b1, 16'h1234, 1'b0, 18, 18, -1, -1);
      begin
        wait (take_data);
        repeat (30) @(negedge clk);
        dec_rst = 1'b1;
        repeat (12) @(negedge clk);
        dec_rst = 1'b0;
      end
    join
    idle_line(1'b0, 40);
    chk(capcnt < 16, "R10 abort stops window", capcnt, 3);
    chk(vwrise == 0, "R10 no valid after abort", vwrise, 0);
    clr_mon();
    send(1'b0, 16'h4321, 1'b0, 18, 18, -1, -1);
    idle_line(1'b0, 40);
    chk(capcnt == 16 && cap == 16'h4321, "R10 recovery after abort", int'(cap), 16'h4321);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule